// File: doc/BRIEF.md
# Interruptible Pseudorandom Generator Controller

This block keeps a two-register pseudorandom generator running. A 64-bit counter advances on every clock. A 128-bit state register is stirred with that counter through a nonlinear mix. Stirring happens on every idle cycle, on request from a consumer, on a query strobe, and once during a power-on refresh. A consumer raises a request and receives a one-cycle grant together with a fresh 64-bit random word. Any instruction activity stops idle stirring in the same cycle, so no other work waits on the generator.

A single-word port to backing storage keeps the counter, the state and an "initialized" flag across power loss. The initialize command loads a seed and writes all four words out. On power-on the controller first reads the flag. If the flag is set, it restores the counter and the state, runs the generator once, and writes the refreshed values back.

Top module: `prng_ctrl`

## Requirements
- R1: `t_o` increases by exactly 1 on every clock edge, except the single edge where it is loaded from storage word 0 during a restore.
- R2: After reset, and on `por_i` while idle, the controller first reads storage word 3. If bit 0 of that word is 0, it returns to idle with no further access and with T and S unchanged.
- R3: If bit 0 of word 3 is 1, the controller reads words 0 (T), 1 (S low) and 2 (S high), mixes S once, then writes T, S low, S high and the flag word (value 1) to words 0, 1, 2 and 3, in that order. The S written equals mix(restored S, written T).
- R4: While `nv_req_o` is high and `nv_done_i` is low, the address, write enable and write data hold steady. Each `nv_done_i` pulse completes exactly one access.
- R5: `por_i` is ignored while a restore or write-back sequence is active (`seq_busy_o` high).
- R6: `init_i` loads `seed_i` into S, then writes the T value of that cycle, the low seed word, the high seed word and the flag word 1 to words 0, 1, 2 and 3, in that order.
- R7: One mix step computes, with A = S[127:64], B = S[63:0] and the current T:
  - new high half = rotl(A,13) XOR (B + T mod 2^64)
  - new low half = rotl(B,29) + (A XOR T) mod 2^64
- R8: A request seen while idle mixes S on that edge. `gnt_o` is then high for exactly one cycle, with `rnd_o` equal to the new high half. If the request is held, grants come at most every other cycle.
- R9: On every idle cycle with `busy_i` low and nothing else pending, S is mixed with the current T and `stir_o` is high.
- R10: `busy_i` or a request stops stirring in the same cycle, with `stir_o` dropping combinationally. A request arriving during stirring is granted one cycle later, like any other request.
- R11: A `query_i` pulse mixes S once even while `busy_i` is high. If it coincides with a request or a sequence, the query is deferred to the next free idle cycle.
- R12: Priority while idle, highest first: `por_i`, `init_i`, request, query, stirring. Grant, stirring and storage access never overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; a restore sequence follows it |
| busy_i | input | 1 | Instruction activity present; blocks idle stirring |
| req_i | input | 1 | Consumer request for a random word |
| gnt_o | output | 1 | One-cycle grant; `rnd_o` valid |
| rnd_o | output | 64 | Random word (upper half of S) |
| query_i | input | 1 | Query strobe; forces one S update |
| init_i | input | 1 | Initialize command |
| seed_i | input | 128 | Seed loaded into S by `init_i` |
| por_i | input | 1 | Start a power-on restore sequence |
| seq_busy_o | output | 1 | Restore or write-back in progress |
| stir_o | output | 1 | S is being stirred this cycle |
| t_o | output | 64 | Current counter value |
| nv_req_o | output | 1 | Storage access request |
| nv_we_o | output | 1 | Storage access is a write |
| nv_addr_o | output | 2 | Storage word address |
| nv_wdata_o | output | 64 | Storage write data |
| nv_rdata_i | input | 64 | Storage read data, valid with `nv_done_i` |
| nv_done_i | input | 1 | Storage access complete (one-cycle pulse) |

## Verification
The hardest case to reach is the full refresh. It needs storage that already holds a set flag and a known state, plus a second power-on pulse that lands inside the running sequence. The bench gets there in three steps. First it runs an initialize command, so its storage model holds a seed it knows. Then it pulses `por_i`, and pulses it again during the reads. Finally it compares the written S against the mix of the restored S and the written T, which it reads from the storage log.

Exact stir counts are also hard to observe. The bench holds `busy_i` high around known windows of idle cycles, then reads the state out through a grant.

// File: rtl/prng_pkg.sv
package prng_pkg;
  localparam int unsigned WORD_W  = 64;
  localparam int unsigned STATE_W = 2 * WORD_W;
  localparam int unsigned ROT_HI  = 13;
  localparam int unsigned ROT_LO  = 29;
  localparam int unsigned NV_AW   = 2;

  typedef enum logic [2:0] {ST_IDLE, ST_GNT, ST_RD, ST_MIX, ST_WR} ctrl_e;
  typedef enum logic [2:0] {S_HOLD, S_MIX, S_SEED, S_LO, S_HI} sop_e;

  function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] x, input int unsigned n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic logic [STATE_W-1:0] mix_fn(input logic [STATE_W-1:0] s,
                                                input logic [WORD_W-1:0]  t);
    logic [WORD_W-1:0] a, b, hi_n, lo_n;
    a    = s[STATE_W-1:WORD_W];
    b    = s[WORD_W-1:0];
    hi_n = rotl(a, ROT_HI) ^ (b + t);
    lo_n = rotl(b, ROT_LO) + (a ^ t);
    return {hi_n, lo_n};
  endfunction
endpackage

// File: rtl/prng_tcnt.sv
module prng_tcnt #(
  parameter int unsigned W = prng_pkg::WORD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] t_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   t_o <= '0;
    else if (ld_i) t_o <= ld_val_i;
    else           t_o <= t_o + {{(W-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/prng_sreg.sv
module prng_sreg
  import prng_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  sop_e               op_i,
  input  logic [STATE_W-1:0] seed_i,
  input  logic [WORD_W-1:0]  word_i,
  input  logic [WORD_W-1:0]  t_i,
  output logic [STATE_W-1:0] s_o,
  output logic [STATE_W-1:0] mix_o
);
  assign mix_o = mix_fn(s_o, t_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s_o <= '0;
    else begin
      unique case (op_i)
        S_MIX:   s_o <= mix_o;
        S_SEED:  s_o <= seed_i;
        S_LO:    s_o[WORD_W-1:0] <= word_i;
        S_HI:    s_o[STATE_W-1:WORD_W] <= word_i;
        default: s_o <= s_o;
      endcase
    end
  end
endmodule

// File: rtl/prng_nvbuf.sv
module prng_nvbuf
  import prng_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               snap_i,
  input  logic [WORD_W-1:0]  t_i,
  input  logic [STATE_W-1:0] s_i,
  input  logic [NV_AW-1:0]   idx_i,
  output logic [WORD_W-1:0]  wdata_o
);
  localparam int unsigned NWORDS = 1 << NV_AW;

  logic [WORD_W-1:0]  buf_t_q;
  logic [STATE_W-1:0] buf_s_q;
  logic [WORD_W-1:0]  words [NWORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_t_q <= '0;
      buf_s_q <= '0;
    end else if (snap_i) begin
      buf_t_q <= t_i;
      buf_s_q <= s_i;
    end
  end

  // word order: T, S low, S high, flag; flag goes last so a cut write never marks valid
  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    if (g == 0)      begin : g_t  assign words[g] = buf_t_q;                      end
    else if (g == 1) begin : g_lo assign words[g] = buf_s_q[WORD_W-1:0];          end
    else if (g == 2) begin : g_hi assign words[g] = buf_s_q[STATE_W-1:WORD_W];    end
    else             begin : g_fl assign words[g] = {{(WORD_W-1){1'b0}}, 1'b1};   end
  end

  assign wdata_o = words[idx_i];
endmodule

// File: rtl/prng_ctrl.sv
module prng_ctrl
  import prng_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               busy_i,
  input  logic               req_i,
  output logic               gnt_o,
  output logic [WORD_W-1:0]  rnd_o,
  input  logic               query_i,
  input  logic               init_i,
  input  logic [STATE_W-1:0] seed_i,
  input  logic               por_i,
  output logic               seq_busy_o,
  output logic               stir_o,
  output logic [WORD_W-1:0]  t_o,
  output logic               nv_req_o,
  output logic               nv_we_o,
  output logic [NV_AW-1:0]   nv_addr_o,
  output logic [WORD_W-1:0]  nv_wdata_o,
  input  logic [WORD_W-1:0]  nv_rdata_i,
  input  logic               nv_done_i
);
  localparam logic [NV_AW-1:0] IDX_LAST = '1;

  ctrl_e              st_q, st_d;
  logic [NV_AW-1:0]   idx_q, idx_d;
  logic               pend_q, pend_d;
  sop_e               s_op;
  logic               t_ld, snap, stir;
  logic [STATE_W-1:0] snap_s, s_q, s_mix;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    pend_d = pend_q | query_i;
    s_op   = S_HOLD;
    t_ld   = 1'b0;
    snap   = 1'b0;
    snap_s = seed_i;
    stir   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (por_i) begin
          st_d  = ST_RD;
          idx_d = '0;
        end else if (init_i) begin
          s_op  = S_SEED;
          snap  = 1'b1;
          st_d  = ST_WR;
          idx_d = '0;
        end else if (req_i) begin
          s_op = S_MIX;
          st_d = ST_GNT;
        end else if (query_i || pend_q) begin
          s_op   = S_MIX;
          pend_d = 1'b0;
        end else if (!busy_i) begin
          s_op = S_MIX;
          stir = 1'b1;
        end
      end
      ST_GNT: st_d = ST_IDLE;
      ST_RD: begin
        if (nv_done_i) begin
          idx_d = idx_q + 1'b1;
          unique case (idx_q)
            2'd0: if (!nv_rdata_i[0]) st_d = ST_IDLE;
            2'd1: t_ld = 1'b1;
            2'd2: s_op = S_LO;
            default: begin
              s_op = S_HI;
              st_d = ST_MIX;
            end
          endcase
        end
      end
      ST_MIX: begin
        s_op   = S_MIX;
        snap   = 1'b1;
        snap_s = s_mix;
        st_d   = ST_WR;
        idx_d  = '0;
      end
      ST_WR: begin
        if (nv_done_i) begin
          idx_d = idx_q + 1'b1;
          if (idx_q == IDX_LAST) st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_RD;
      idx_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      pend_q <= pend_d;
    end
  end

  prng_tcnt #(.W(WORD_W)) u_tcnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_i    (t_ld),
    .ld_val_i(nv_rdata_i),
    .t_o     (t_o)
  );

  prng_sreg u_sreg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .op_i  (s_op),
    .seed_i(seed_i),
    .word_i(nv_rdata_i),
    .t_i   (t_o),
    .s_o   (s_q),
    .mix_o (s_mix)
  );

  prng_nvbuf u_nvbuf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .snap_i (snap),
    .t_i    (t_o),
    .s_i    (snap_s),
    .idx_i  (idx_q),
    .wdata_o(nv_wdata_o)
  );

  // read order is flag first, then T, S low, S high: address = idx - 1
  assign nv_req_o   = (st_q == ST_RD) || (st_q == ST_WR);
  assign nv_we_o    = (st_q == ST_WR);
  assign nv_addr_o  = (st_q == ST_RD) ? idx_q - 1'b1 : idx_q;
  assign seq_busy_o = (st_q == ST_RD) || (st_q == ST_MIX) || (st_q == ST_WR);
  assign gnt_o      = (st_q == ST_GNT);
  assign rnd_o      = s_q[STATE_W-1:WORD_W];
  assign stir_o     = stir;
endmodule

// File: rtl/prng_ctrl_chk.sv
module prng_ctrl_chk
  import prng_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              t_ld,
  input logic [WORD_W-1:0] t_o,
  input logic              gnt_o,
  input logic              req_i,
  input logic              busy_i,
  input logic              stir_o,
  input logic              nv_req_o,
  input logic              nv_we_o,
  input logic [NV_AW-1:0]  nv_addr_o,
  input logic [WORD_W-1:0] nv_wdata_o,
  input logic              nv_done_i
);
  assert_t_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !t_ld |=> t_o == $past(t_o) + 64'd1);

  assert_nv_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_req_o && !nv_done_i |=> nv_req_o && $stable(nv_addr_o) && $stable(nv_we_o)
                               && $stable(nv_wdata_o));

  assert_gnt_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o |=> !gnt_o);

  assert_gnt_after_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o |-> $past(req_i));

  assert_busy_stops_stir_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i || req_i |-> !stir_o);

  assert_exclusive_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({gnt_o, stir_o, nv_req_o}));
endmodule

bind prng_ctrl prng_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .t_ld      (t_ld),
  .t_o       (t_o),
  .gnt_o     (gnt_o),
  .req_i     (req_i),
  .busy_i    (busy_i),
  .stir_o    (stir_o),
  .nv_req_o  (nv_req_o),
  .nv_we_o   (nv_we_o),
  .nv_addr_o (nv_addr_o),
  .nv_wdata_o(nv_wdata_o),
  .nv_done_i (nv_done_i)
);

// File: tb/sim_prng_ctrl.sv
`timescale 1ns/1ps
module sim_prng_ctrl;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic busy_i = 1'b1, req_i = 1'b0, query_i = 1'b0, init_i = 1'b0, por_i = 1'b0;
  logic [127:0] seed_i = '0;
  logic gnt_o, seq_busy_o, stir_o, nv_req_o, nv_we_o;
  logic [63:0] rnd_o, t_o, nv_wdata_o;
  logic [1:0]  nv_addr_o;
  logic [63:0] nv_rdata_i = '0;
  logic        nv_done_i = 1'b0;

  int vec = 0, bad = 0;
  logic [63:0]  mem [4];
  logic [1:0]   la [64];
  logic         lwe [64];
  logic [63:0]  ldat [64];
  int           nlog = 0;
  logic [127:0] ms;

  always #4 clk_i = ~clk_i;

  prng_ctrl u0 (.*);

  function automatic logic [63:0] rl(input logic [63:0] x, input int n);
    return (x << n) | (x >> (64 - n));
  endfunction

  function automatic logic [127:0] bmix(input logic [127:0] s, input logic [63:0] t);
    return {rl(s[127:64], 13) ^ (s[63:0] + t), rl(s[63:0], 29) + (s[127:64] ^ t)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic wait_seq();
    for (int k = 0; k < 200 && seq_busy_o; k++) step();
  endtask

  // storage model: done two cycles into each request
  initial begin
    int wcnt = 0;
    for (int i = 0; i < 4; i++) mem[i] = '0;
    forever begin
      @(negedge clk_i);
      if (nv_done_i) begin
        nv_done_i = 1'b0;
        wcnt = 0;
      end else if (nv_req_o) begin
        wcnt++;
        if (wcnt == 2) begin
          nv_done_i  = 1'b1;
          nv_rdata_i = mem[nv_addr_o];
          if (nv_we_o) mem[nv_addr_o] = nv_wdata_o;
          if (nlog < 64) begin
            la[nlog] = nv_addr_o; lwe[nlog] = nv_we_o; ldat[nlog] = nv_wdata_o;
            nlog++;
          end
        end
      end else wcnt = 0;
    end
  end

  task automatic do_req(input string tag);
    logic [63:0] tt;
    req_i = 1'b1; tt = t_o;
    step();
    req_i = 1'b0;
    ms = bmix(ms, tt);
    chk(gnt_o === 1'b1, {tag, " grant"}, 128'(gnt_o), 128'd1);
    chk(rnd_o === ms[127:64], {tag, " word"}, 128'(rnd_o), 128'(ms[127:64]));
    step();
    chk(gnt_o === 1'b0, {tag, " grant drop"}, 128'(gnt_o), 128'd0);
  endtask

  task automatic t_reset();
    logic [63:0] a;
    step(); rst_ni = 1'b1; step();
    chk(seq_busy_o && nv_addr_o == 2'd3 && !nv_we_o, "R2 first read flag", 128'(nv_addr_o), 128'd3);
    chk(gnt_o === 1'b0, "R8 no grant in reset", 128'(gnt_o), 128'd0);
    wait_seq();
    chk(nlog == 1 && la[0] == 2'd3 && !lwe[0], "R2 only flag read", 128'(nlog), 128'd1);
    a = t_o; step();
    chk(t_o == a + 64'd1, "R1 counter step", 128'(t_o), 128'(a + 64'd1));
    ms = '0;
    do_req("R2 R7 reset state");
  endtask

  task automatic t_init(input logic [127:0] sd, input bit with_req);
    logic [63:0] ts;
    int b;
    b = nlog;
    init_i = 1'b1; seed_i = sd; ts = t_o; req_i = with_req;
    step();
    init_i = 1'b0;
    if (with_req) chk(gnt_o === 1'b0 && seq_busy_o, "R12 init before request", 128'(gnt_o), 128'd0);
    req_i = 1'b0;
    wait_seq();
    chk(nlog - b == 4, "R6 write count", 128'(nlog - b), 128'd4);
    chk(la[b] == 0 && lwe[b] && ldat[b] == ts, "R6 T word", 128'(ldat[b]), 128'(ts));
    chk(la[b+1] == 1 && ldat[b+1] == sd[63:0], "R6 S low", 128'(ldat[b+1]), 128'(sd[63:0]));
    chk(la[b+2] == 2 && ldat[b+2] == sd[127:64], "R6 S high", 128'(ldat[b+2]), 128'(sd[127:64]));
    chk(la[b+3] == 3 && ldat[b+3] == 64'd1, "R6 flag", 128'(ldat[b+3]), 128'd1);
    ms = sd;
  endtask

  task automatic t_held(input int n);
    logic [63:0] ta;
    req_i = 1'b1;
    for (int k = 0; k < n; k++) begin
      ta = t_o; step();
      ms = bmix(ms, ta);
      chk(gnt_o === 1'b1 && rnd_o == ms[127:64], "R8 held request word", 128'(rnd_o), 128'(ms[127:64]));
      step();
      chk(gnt_o === 1'b0, "R8 held request gap", 128'(gnt_o), 128'd0);
    end
    req_i = 1'b0;
  endtask

  task automatic t_query();
    logic [63:0] t1, tp;
    query_i = 1'b1; t1 = t_o; step(); query_i = 1'b0;
    ms = bmix(ms, t1);
    step();
    do_req("R11 query while busy");
    query_i = 1'b1; req_i = 1'b1; t1 = t_o; step();
    query_i = 1'b0; req_i = 1'b0;
    ms = bmix(ms, t1);
    chk(gnt_o === 1'b1 && rnd_o == ms[127:64], "R12 request over query", 128'(rnd_o), 128'(ms[127:64]));
    step(); tp = t_o; ms = bmix(ms, tp);
    step();
    do_req("R11 deferred query");
  endtask

  task automatic t_stir();
    logic [63:0] t0, tt;
    busy_i = 1'b0; t0 = t_o; #1;
    chk(stir_o === 1'b1, "R9 stir flag", 128'(stir_o), 128'd1);
    repeat (5) step();
    busy_i = 1'b1; #1;
    chk(stir_o === 1'b0, "R10 busy stops stir", 128'(stir_o), 128'd0);
    for (int k = 0; k < 5; k++) ms = bmix(ms, t0 + 64'(k));
    step();
    do_req("R9 five stirs");
    busy_i = 1'b0; t0 = t_o; step();
    req_i = 1'b1; tt = t_o; #1;
    chk(stir_o === 1'b0, "R10 request preempts", 128'(stir_o), 128'd0);
    step();
    busy_i = 1'b1; req_i = 1'b0;
    ms = bmix(bmix(ms, t0), tt);
    chk(gnt_o === 1'b1 && rnd_o == ms[127:64], "R10 grant after preempt", 128'(rnd_o), 128'(ms[127:64]));
    step();
  endtask

  task automatic t_refresh();
    logic [63:0] tm, tw;
    logic [127:0] sm, ex;
    int b;
    b = nlog; tm = mem[0]; sm = {mem[2], mem[1]};
    por_i = 1'b1; step(); por_i = 1'b0;
    repeat (3) step();
    por_i = 1'b1; step(); por_i = 1'b0;
    wait_seq();
    chk(nlog - b == 8, "R3 access count", 128'(nlog - b), 128'd8);
    chk(la[b] == 3 && la[b+1] == 0 && la[b+2] == 1 && la[b+3] == 2 && !lwe[b+3],
        "R3 read order", 128'(la[b+1]), 128'd0);
    tw = ldat[b+4];
    chk(la[b+4] == 0 && lwe[b+4] && tw > tm && tw - tm < 64'd32, "R1 R3 restored T", 128'(tw), 128'(tm));
    ex = bmix(sm, tw);
    chk(ldat[b+5] == ex[63:0] && ldat[b+6] == ex[127:64], "R3 R7 refreshed S",
        {ldat[b+6], ldat[b+5]}, ex);
    chk(la[b+7] == 3 && ldat[b+7] == 64'd1, "R3 flag last", 128'(ldat[b+7]), 128'd1);
    ms = ex;
    repeat (4) step();
    chk(nlog - b == 8 && !seq_busy_o, "R5 second por ignored", 128'(nlog - b), 128'd8);
    do_req("R3 state after refresh");
  endtask

  task automatic t_no_flag();
    int b;
    mem[3] = 64'd0; b = nlog;
    por_i = 1'b1; step(); por_i = 1'b0;
    wait_seq();
    chk(nlog - b == 1 && la[b] == 3 && !lwe[b], "R2 flag clear stops", 128'(nlog - b), 128'd1);
    do_req("R2 S untouched");
  endtask

  initial begin
    #(8 * 20000);
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_init(128'h0123456789abcdef_fedcba9876543210, 1'b0);
    do_req("R8 single request");
    t_held(3);
    t_query();
    t_stir();
    t_init(128'hdeadbeef00c0ffee_5a5a5a5a12345678, 1'b1);
    t_refresh();
    t_no_flag();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule